// File: doc/BRIEF.md
# Reed-Solomon Page Signature Generator

This block computes a Reed-Solomon check signature over a 512-byte flash page as the page streams past, one byte per valid cycle, at full rate. The bytes are repacked into 10-bit symbols of GF(2^10), and a four-stage division register holds the running remainder by a degree-4 generator polynomial. Four parity symbols (40 bits) let a corrector elsewhere repair up to two symbol errors. This block only produces parity and detects errors. It never locates or corrects them.

A direction bit, sampled with the start-of-page byte, selects the mode. In a write page the host streams 512 bytes. The block then presents a 6-byte signature: five bytes of parity and one fill byte. In a read page the host streams the 512 data bytes followed by the 6 stored signature bytes. The block then reports whether the recomputed remainder over data plus stored parity is non-zero. A one-cycle done strobe marks each result.

Top module: `rs_page_sig`

## Requirements
- R1: Field and code. Arithmetic is in GF(2^10) with reduction polynomial x^10+x^3+1. The generator is g(x)=(x+a)(x+a^2)(x+a^3)(x+a^4) with a=x. The write parity is the remainder of D(x)·x^4 divided by g(x), where D(x) has its first symbol at the highest degree.
- R2: Symbol packing. The page bits form a stream in which bit i of byte j is stream bit 8j+i. Symbol s takes stream bits 10s..10s+9, with the lowest stream bit as the symbol LSB. This gives 410 symbols, and the last symbol has four zero bits in its upper positions.
- R3: Signature layout. sig_out[9:0] holds the degree-3 remainder coefficient, followed in turn by degrees 2, 1 and 0 up to sig_out[39:0]. Signature byte k is sig_out[8k+7:8k]. Byte 5 (sig_out[47:40]) is always 0xFF.
- R4: Write timing. If the last data byte of a write page is accepted in cycle k, done is high in cycle k+2 and sig_out holds that page's signature from then on.
- R5: Read check. In a read page, bytes 512..516 are the stored signature bytes 0..4. If the last byte (byte 517) is accepted in cycle k, done is high in cycle k+1. err is then 1 exactly when the stored parity differs from the parity of the received data.
- R6: Byte 517 of a read page (the fill byte) has no effect on err.
- R7: A read page leaves sig_out unchanged. The done of a write page drives err to 0. err changes only together with done.
- R8: Cycles with in_valid low inside a page have no effect, and in_byte is ignored in them. Bytes that arrive with in_valid high outside a page (no in_sop seen since the last page ended) are ignored.
- R9: in_sop with in_valid high always starts a fresh page, even in the middle of a page. Earlier bytes do not affect the new result.
- R10: A new page may start in the cycle right after the last data byte of a write page. Both signatures are then still correct.
- R11: After reset, done=0, err=0, sig_out[39:0]=0 and sig_out[47:40]=0xFF.
- R12: done is high for exactly one cycle per finished page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sop | input | 1 | This byte is the first byte of a page |
| in_dir_rd | input | 1 | Mode, sampled with in_sop: 1 = read/check, 0 = write/generate |
| in_byte | input | 8 | Stream byte |
| sig_out | output | 48 | Last write signature, bytes 0..5 from the LSB up |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Read remainder non-zero, valid with done |

## Verification
The bench compares every signature against its own long division over the packed symbols. This catches a design that shifts symbols in the wrong bit order, pads the last symbol wrongly or drops that symbol, or reverses the parity order, since any of these gives a different signature on random pages. Read pages are run clean, with one data bit flipped, with one parity bit flipped, and with a corrupted fill byte. A design that checks the fill byte or mis-aligns the parity symbols would then raise err on a clean page or miss a flipped bit. A write page is immediately followed by a new start-of-page, and a page is restarted midway. A design that lets the clear win over the pending pad step would corrupt the first signature, and one that keeps old state across the restart would corrupt the second. Stray bytes sent outside any page and random idle gaps with junk data show whether the design lets unaccepted bytes into the remainder.

// File: rtl/rs_sig_pkg.sv
package rs_sig_pkg;
  localparam int GF_W    = 10;
  localparam int RS_NPAR = 4;
  localparam logic [GF_W-1:0] GF_POLY_LOW = 10'h009; // x^10 + x^3 + 1

  typedef logic [GF_W-1:0] gf_sym_t;

  // shift-and-add multiply in GF(2^10)
  function automatic gf_sym_t gf_mul(gf_sym_t a, gf_sym_t b);
    gf_sym_t acc;
    gf_sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[GF_W-2:0], 1'b0} ^ (sh[GF_W-1] ? GF_POLY_LOW : '0);
    end
    return acc;
  endfunction

  // low coefficients of the monic generator with roots a^1..a^RS_NPAR
  function automatic logic [RS_NPAR*GF_W-1:0] gen_coefs();
    gf_sym_t g [RS_NPAR+1];
    gf_sym_t root;
    logic [RS_NPAR*GF_W-1:0] packed_g;
    g[0] = gf_sym_t'(1);
    for (int j = 1; j <= RS_NPAR; j++) g[j] = '0;
    root = gf_sym_t'(1);
    for (int i = 1; i <= RS_NPAR; i++) begin
      root = gf_mul(root, gf_sym_t'(2));
      for (int j = RS_NPAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
    end
    for (int j = 0; j < RS_NPAR; j++) packed_g[j*GF_W +: GF_W] = g[j];
    return packed_g;
  endfunction
endpackage

// File: rtl/rs_sym_pack.sv
module rs_sym_pack
  import rs_sig_pkg::*;
#(
  parameter int SYM_W  = GF_W,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_v,
  input  logic             clr,      // start from empty before merging
  input  logic             cut,      // after merging, hand out the rest and empty
  input  logic [BYTE_W-1:0] byte_in,
  output logic             sym_v,
  output logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] rest
);
  localparam int AW = SYM_W + BYTE_W - 1;
  localparam int CW = $clog2(AW + 1);

  logic [AW-1:0] acc_q, acc_d, base_acc, merged, after_acc;
  logic [CW-1:0] cnt_q, cnt_d, base_cnt, total, after_cnt;

  always_comb begin
    base_acc  = clr ? '0 : acc_q;
    base_cnt  = clr ? '0 : cnt_q;
    merged    = base_acc | ({{(AW-BYTE_W){1'b0}}, byte_in} << base_cnt);
    total     = base_cnt + CW'(BYTE_W);
    sym_v     = byte_v && (total >= CW'(SYM_W));
    sym       = merged[SYM_W-1:0];
    after_acc = sym_v ? (merged >> SYM_W) : merged;
    after_cnt = sym_v ? (total - CW'(SYM_W)) : total;
    rest      = after_acc[SYM_W-1:0];
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    if (byte_v) begin
      acc_d = cut ? '0 : after_acc;
      cnt_d = cut ? '0 : after_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: never more than one symbol's worth of bits held back
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SYM_W));
endmodule

// File: rtl/rs_lfsr_div.sv
module rs_lfsr_div
  import rs_sig_pkg::*;
(
  input  logic                      en,
  input  logic [GF_W-1:0]           sym,
  input  logic [RS_NPAR*GF_W-1:0]   cur,
  output logic [RS_NPAR*GF_W-1:0]   nxt
);
  localparam logic [RS_NPAR*GF_W-1:0] GCO = gen_coefs();

  logic [GF_W-1:0]         fb;
  logic [RS_NPAR*GF_W-1:0] stepped;

  assign fb = sym ^ cur[(RS_NPAR-1)*GF_W +: GF_W];

  for (genvar j = 0; j < RS_NPAR; j++) begin : g_stage
    if (j == 0) begin : g_low
      assign stepped[0 +: GF_W] = gf_mul(fb, GCO[0 +: GF_W]);
    end else begin : g_up
      assign stepped[j*GF_W +: GF_W] = cur[(j-1)*GF_W +: GF_W]
                                     ^ gf_mul(fb, GCO[j*GF_W +: GF_W]);
    end
  end

  assign nxt = en ? stepped : cur;
endmodule

// File: rtl/rs_page_sig.sv
module rs_page_sig
  import rs_sig_pkg::*;
#(
  parameter int          PAGE_BYTES = 512,
  parameter logic [7:0]  SIG_FILL   = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_dir_rd,
  input  logic [7:0]  in_byte,
  output logic [47:0] sig_out,
  output logic        done,
  output logic        err
);
  localparam int PAR_BITS  = RS_NPAR * GF_W;
  localparam int PAR_BYTES = (PAR_BITS + 7) / 8;
  localparam int SIG_BYTES = PAR_BYTES + 1;
  localparam int TOTAL_RD  = PAGE_BYTES + SIG_BYTES;
  localparam int IDX_W     = $clog2(TOTAL_RD + 1);
  localparam bit HAS_PAD   = ((PAGE_BYTES * 8) % GF_W) != 0;
  localparam logic [IDX_W-1:0] LAST_WR = IDX_W'(PAGE_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_RD = IDX_W'(TOTAL_RD - 1);

  logic                 active_q, active_d;
  logic                 rd_q, rd_d;
  logic [IDX_W-1:0]     idx_q, idx_d, cur_idx;
  logic                 flush_q, flush_d, pwr_q, pwr_d;
  logic [GF_W-1:0]      pad_q, pad_d;
  logic [PAR_BITS-1:0]  rem_q, rem_d, div_out, par_view;
  logic [PAR_BITS-1:0]  sig_q, sig_d;
  logic                 done_q, done_d, err_q, err_d;
  logic                 accept, cur_rd, last_data, last_all;
  logic                 pk_v;
  logic [GF_W-1:0]      pk_sym, pk_rest, div_sym;
  logic                 div_en;

  rs_sym_pack u_pack (
    .clk(clk), .rst_n(rst_n), .byte_v(accept), .clr(in_sop),
    .cut(last_data | last_all), .byte_in(in_byte),
    .sym_v(pk_v), .sym(pk_sym), .rest(pk_rest)
  );

  assign div_en  = (flush_q && HAS_PAD) || pk_v;
  assign div_sym = flush_q ? pad_q : pk_sym;

  rs_lfsr_div u_div (.en(div_en), .sym(div_sym), .cur(rem_q), .nxt(div_out));

  // highest-degree parity symbol goes first, in the low bits
  for (genvar k = 0; k < RS_NPAR; k++) begin : g_order
    assign par_view[k*GF_W +: GF_W] = div_out[(RS_NPAR-1-k)*GF_W +: GF_W];
  end

  always_comb begin
    accept    = in_valid && (in_sop || active_q);
    cur_idx   = in_sop ? '0 : idx_q;
    cur_rd    = in_sop ? in_dir_rd : rd_q;
    last_data = accept && (cur_idx == LAST_WR);
    last_all  = accept && (cur_idx == (cur_rd ? LAST_RD : LAST_WR));

    active_d  = accept ? !last_all : active_q;
    rd_d      = accept ? cur_rd : rd_q;
    idx_d     = accept ? cur_idx + IDX_W'(1) : idx_q;
    flush_d   = last_data;
    pwr_d     = last_data && !cur_rd;
    pad_d     = last_data ? pk_rest : pad_q;

    rem_d     = (accept && in_sop) ? '0 : div_out;

    sig_d     = (flush_q && pwr_q) ? par_view : sig_q;
    done_d    = (flush_q && pwr_q) || (last_all && cur_rd);
    err_d     = err_q;
    if (flush_q && pwr_q)      err_d = 1'b0;
    else if (last_all && cur_rd) err_d = |div_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      flush_q  <= 1'b0;
      pwr_q    <= 1'b0;
      pad_q    <= '0;
      rem_q    <= '0;
      sig_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      idx_q    <= idx_d;
      flush_q  <= flush_d;
      pwr_q    <= pwr_d;
      pad_q    <= pad_d;
      rem_q    <= rem_d;
      sig_q    <= sig_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign sig_out = {SIG_FILL, sig_q};
  assign done    = done_q;
  assign err     = err_q;

  // R12: result strobe lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: signature only moves with a write result
  a_r7_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sig_q) |-> (done_q && !err_q));
  // R5: error flag only moves with a result
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> done_q);
  // R10: the pad step never competes with a packed symbol
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !pk_v);
  // R8: the byte index stays inside the longest page
  a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q < IDX_W'(TOTAL_RD)));
endmodule

// File: tb/rs_page_sig_test.sv
`timescale 1ns/100ps
module rs_page_sig_test;
  logic clk, rst_n, in_valid, in_sop, in_dir_rd;
  logic [7:0]  in_byte;
  logic [47:0] sig_out;
  logic done, err;
  int n_chk, n_fail;
  logic [7:0] page [0:517];

  rs_page_sig uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_dir_rd(in_dir_rd), .in_byte(in_byte), .sig_out(sig_out), .done(done), .err(err));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // carry-less product then polynomial reduction
  function automatic logic [9:0] fmul(logic [9:0] a, logic [9:0] b);
    logic [18:0] p;
    p = '0;
    for (int i = 0; i < 10; i++) if (b[i]) p = p ^ (19'(a) << i);
    for (int i = 18; i >= 10; i--) if (p[i]) p = p ^ (19'h409 << (i - 10));
    return p[9:0];
  endfunction

  function automatic logic [39:0] ref_sig();
    logic [9:0] g [5];
    logic [9:0] r [4];
    logic [9:0] root, s, fb;
    logic [39:0] o;
    g[0] = 10'd1; g[1] = '0; g[2] = '0; g[3] = '0; g[4] = '0;
    root = 10'd1;
    for (int i = 1; i <= 4; i++) begin
      root = fmul(root, 10'd2);
      for (int j = 4; j >= 1; j--) g[j] = g[j-1] ^ fmul(g[j], root);
      g[0] = fmul(g[0], root);
    end
    for (int j = 0; j < 4; j++) r[j] = '0;
    for (int si = 0; si < 410; si++) begin
      s = '0;
      for (int b = 0; b < 10; b++) begin
        int bit_i;
        bit_i = si * 10 + b;
        if (bit_i < 4096) s[b] = page[bit_i / 8][bit_i % 8];
      end
      fb = s ^ r[3];
      for (int j = 3; j >= 1; j--) r[j] = r[j-1] ^ fmul(fb, g[j]);
      r[0] = fmul(fb, g[0]);
    end
    for (int k = 0; k < 4; k++) o[k*10 +: 10] = r[3-k];
    return o;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 512; i++) page[i] = 8'($urandom);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_byte = 8'($urandom); in_dir_rd = 1'($urandom);
  endtask

  task automatic drive_page(input bit rd, input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      while (i > 0 && int'($urandom % 100) < gap_pct) idle();
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_byte = page[i];
      in_dir_rd = (i == 0) ? rd : 1'($urandom);
    end
  endtask

  task automatic finish_write(input logic [39:0] exp, input string req);
    idle();
    chk("R4 done not yet", 64'(done), 64'd0);
    @(negedge clk);
    chk("R4 done", 64'(done), 64'd1);
    chk(req, 64'(sig_out), {16'h0, 8'hFF, exp});
    chk("R7 err cleared on write", 64'(err), 64'd0);
    @(negedge clk);
    chk("R12 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic finish_read(input bit exp_err, input logic [47:0] prev, input string req);
    idle();
    chk("R5 read done", 64'(done), 64'd1);
    chk(req, 64'(err), 64'(exp_err));
    chk("R7 read keeps sig", 64'(sig_out), 64'(prev));
    @(negedge clk);
    chk("R12 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic load_sig(input logic [39:0] s);
    for (int k = 0; k < 5; k++) page[512+k] = s[8*k +: 8];
    page[517] = 8'hFF;
  endtask

  initial begin
    logic [39:0] ea, eb;
    logic [47:0] held;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_dir_rd = 1'b0; in_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset sig", 64'(sig_out), 64'h0000_FF00_0000_0000);
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R11 reset err", 64'(err), 64'd0);

    // R8: stray bytes before any page
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'($urandom);
    end
    idle(); idle();
    chk("R8 stray no done", 64'(done), 64'd0);
    chk("R8 stray sig", 64'(sig_out), 64'h0000_FF00_0000_0000);

    // R1 R2 R3: directed patterns
    for (int i = 0; i < 512; i++) page[i] = 8'h00;
    drive_page(1'b0, 512, 0);
    finish_write(40'h0, "R1 zero page");
    for (int i = 0; i < 512; i++) page[i] = 8'hFF;
    ea = ref_sig();
    drive_page(1'b0, 512, 0);
    finish_write(ea, "R2 all-ones page pad");
    for (int i = 0; i < 512; i++) page[i] = (i == 511) ? 8'h80 : 8'h00;
    ea = ref_sig();
    drive_page(1'b0, 512, 0);
    finish_write(ea, "R3 last-bit page");

    // random write pages, with and without gaps (R8)
    for (int p = 0; p < 4; p++) begin
      fill_random();
      ea = ref_sig();
      drive_page(1'b0, 512, (p % 2) * 30);
      finish_write(ea, p[0] ? "R8 gapped write sig" : "R1 random write sig");
    end

    // read pages
    fill_random();
    ea = ref_sig();
    drive_page(1'b0, 512, 0);
    finish_write(ea, "R1 write before read");
    held = sig_out;
    load_sig(ea);
    drive_page(1'b1, 518, 20);
    finish_read(1'b0, held, "R5 clean read");
    page[517] = 8'h3C;
    drive_page(1'b1, 518, 0);
    finish_read(1'b0, held, "R6 fill byte ignored");
    page[517] = 8'hFF;
    page[100] = page[100] ^ 8'h10;
    drive_page(1'b1, 518, 0);
    finish_read(1'b1, held, "R5 data bit flip");
    page[100] = page[100] ^ 8'h10;
    page[515] = page[515] ^ 8'h01;
    drive_page(1'b1, 518, 0);
    finish_read(1'b1, held, "R5 parity bit flip");
    page[515] = page[515] ^ 8'h01;
    page[511] = page[511] ^ 8'h80;
    drive_page(1'b1, 518, 0);
    finish_read(1'b1, held, "R5 last data bit flip");
    fill_random();
    ea = ref_sig();
    drive_page(1'b0, 512, 0);
    finish_write(ea, "R7 write after failed read");

    // R8: bytes right after a write page are ignored
    fill_random();
    ea = ref_sig();
    drive_page(1'b0, 512, 0);
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'($urandom);
    chk("R8 tail no early done", 64'(done), 64'd0);
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'($urandom);
    chk("R8 tail done", 64'(done), 64'd1);
    chk("R8 tail sig", 64'(sig_out), {16'h0, 8'hFF, ea});
    @(negedge clk); in_valid = 1'b1; in_byte = 8'($urandom);
    idle(); idle();
    chk("R8 tail no second done", 64'(done), 64'd0);
    chk("R8 tail sig held", 64'(sig_out), {16'h0, 8'hFF, ea});

    // R9: restart mid page
    fill_random();
    drive_page(1'b0, 200, 0);
    fill_random();
    ea = ref_sig();
    drive_page(1'b0, 512, 10);
    finish_write(ea, "R9 restart sig");

    // R10: back-to-back write pages
    fill_random();
    ea = ref_sig();
    drive_page(1'b0, 512, 0);
    fork
      begin
        @(negedge clk); @(negedge clk);
        chk("R10 first done", 64'(done), 64'd1);
        chk("R10 first sig", 64'(sig_out), {16'h0, 8'hFF, ea});
      end
    join_none
    fill_random();
    eb = ref_sig();
    drive_page(1'b0, 512, 0);
    finish_write(eb, "R10 second sig");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule